// File: doc/BRIEF.md
# Link-side shared-bus PHY controller

This block sits on the link side of a narrow PHY interface in which a single 8-bit data bus is shared by both directions, and the PHY decides who owns it. The block runs entirely on the clock the PHY supplies. When the link owns the bus and has nothing to send, it drives zero. To send a packet it takes bytes from a local transmit stream with valid, ready and last. It first places a fixed non-zero command byte on the bus, then the payload bytes one at a time, each advanced by the PHY's next-byte strobe. When the PHY has taken the final byte, the block raises the stop line for one clock.

When the PHY raises its direction line, the link releases the bus. After the turnaround cycle, every byte the PHY flags with the strobe is handed out on a receive stream. The strobe therefore means "give me the next byte" while direction is low and "this byte is valid" while direction is high. When direction falls, the block pulses a receive-end flag. If the PHY takes the bus back in the middle of a transmit, the block reports an abort, discards the rest of that packet from the stream and does not signal stop.

Top module: `lnk_bus_ctrl`

## Requirements
- R1: On synchronous reset, `bus_oe` is 1, `bus_out` is 0, and `phy_stp`, `rx_valid`, `rx_last`, `tx_abort` and `tx_ready` are all 0.
- R2: While `bus_oe` is 1 and no packet is in progress, `bus_out` is 0, whatever `phy_nxt` does.
- R3: Every packet begins with the command byte `CMD_BYTE` (default 0x5A, must be non-zero) on `bus_out`, before any payload byte.
- R4: With `phy_dir` low, `phy_nxt` high at a clock edge means the byte on `bus_out` is taken. The next stream byte appears on `bus_out` in the following cycle, in stream order. `tx_ready` is high in exactly the cycles where a stream byte is taken.
- R5: In the cycle after the final payload byte is taken, `phy_stp` is 1 for exactly one cycle and `bus_out` is 0.
- R6: `bus_oe` is 0 in the cycle after any edge that samples `phy_dir` high. It is 1 again only after two consecutive edges have sampled `phy_dir` low; the first of those edges is the turnaround.
- R7: An edge that samples `phy_dir` high, following an edge that also sampled it high, with `phy_nxt` high, gives `rx_valid`=1 for one cycle in the next cycle, with `rx_data` equal to the sampled `bus_in`. At the turnaround edge nothing is captured.
- R8: `rx_last` is 1 for one cycle after the edge at which `phy_dir` is first sampled low following a high sample.
- R9: If `phy_dir` is sampled high while the command or a payload byte is on the bus, `tx_abort` pulses for one cycle, `phy_stp` stays 0, and the unsent rest of the packet is drained from the transmit stream.
- R10: A transmit does not start while `phy_dir` is high or during the turnaround that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock supplied by the PHY |
| rst | input | 1 | Synchronous active-high reset |
| tx_valid | input | 1 | Transmit stream byte available |
| tx_data | input | 8 | Transmit stream byte |
| tx_last | input | 1 | Marks the final byte of a packet |
| tx_ready | output | 1 | Stream byte taken this cycle |
| tx_abort | output | 1 | One-cycle pulse: packet cut short by the PHY |
| phy_dir | input | 1 | Bus direction from the PHY, high = PHY drives |
| phy_nxt | input | 1 | Next-byte or byte-valid strobe from the PHY |
| phy_stp | output | 1 | One-cycle end-of-packet indication to the PHY |
| bus_in | input | 8 | Data bus as seen from the pads |
| bus_out | output | 8 | Data the link drives onto the bus |
| bus_oe | output | 1 | Output enable for the bus drivers |
| rx_valid | output | 1 | Received byte present |
| rx_data | output | 8 | Received byte |
| rx_last | output | 1 | Pulse when the PHY hands the bus back |

## Verification
Transmit runs use payloads of one byte up to twelve bytes with the strobe held high or thinned at random. This separates correct byte ordering and stop timing from off-by-one pacing errors and from a repeated or skipped byte. Receive bursts with random strobe and data show whether the turnaround cycle is excluded and whether the receive-end pulse lands on the falling edge of direction. Directed cases take the bus away during the command, in mid-payload and while the final byte waits on the bus, and offer a packet while direction is high. These show whether the abort drains the stream exactly to the packet end and whether a start can leak into the turnaround. A reset in the middle of a packet exposes any state that survives reset.

// File: rtl/lnk_bus_pkg.sv
package lnk_bus_pkg;

    localparam int unsigned BUS_W = 8;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_CMD,
        TX_DATA,
        TX_STOP,
        TX_FLUSH
    } tx_state_e;

    // link may drive the bus only when the PHY has left it on two edges running
    function automatic logic link_window(input logic dir_now, input logic dir_prev);
        return !dir_now && !dir_prev;
    endfunction

    // PHY byte is real only outside the turnaround
    function automatic logic phy_window(input logic dir_now, input logic dir_prev);
        return dir_now && dir_prev;
    endfunction

endpackage

// File: rtl/lnk_dir_track.sv
module lnk_dir_track
    import lnk_bus_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic dir,
    output logic dir_q,
    output logic quiet,
    output logic oe_q
);

    assign quiet = link_window(dir, dir_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q <= 1'b0;
            oe_q  <= 1'b1;
        end else begin
            dir_q <= dir;
            oe_q  <= quiet;
        end
    end

endmodule

// File: rtl/lnk_rx_path.sv
module lnk_rx_path
    import lnk_bus_pkg::*;
#(
    parameter int unsigned DW = BUS_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          dir,
    input  logic          dir_q,
    input  logic          nxt,
    input  logic [DW-1:0] bus_in,
    output logic          rx_valid,
    output logic [DW-1:0] rx_data,
    output logic          rx_last
);

    logic capture;
    assign capture = phy_window(dir, dir_q) && nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_valid <= 1'b0;
            rx_data  <= '0;
            rx_last  <= 1'b0;
        end else begin
            rx_valid <= capture;
            if (capture) begin
                rx_data <= bus_in;
            end
            rx_last <= dir_q && !dir;
        end
    end

endmodule

// File: rtl/lnk_tx_fsm.sv
module lnk_tx_fsm
    import lnk_bus_pkg::*;
#(
    parameter int unsigned    DW       = BUS_W,
    parameter logic [DW-1:0]  CMD_BYTE = 8'h5A
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          dir,
    input  logic          quiet,
    input  logic          nxt,
    input  logic          tx_valid,
    input  logic [DW-1:0] tx_data,
    input  logic          tx_last,
    output logic          tx_ready,
    output logic [DW-1:0] bus_out,
    output logic          stp,
    output logic          tx_abort
);

    tx_state_e state;
    logic      last_q;
    logic      take;
    logic      final_on_bus;

    assign final_on_bus = (state == TX_DATA) && last_q;

    always_comb begin
        take = 1'b0;
        unique case (state)
            TX_CMD:   take = !dir && nxt;
            TX_DATA:  take = !dir && nxt && !last_q;
            TX_FLUSH: take = 1'b1;
            default:  take = 1'b0;
        endcase
    end

    assign tx_ready = take;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= TX_IDLE;
            last_q   <= 1'b0;
            bus_out  <= '0;
            stp      <= 1'b0;
            tx_abort <= 1'b0;
        end else begin
            stp      <= 1'b0;
            tx_abort <= 1'b0;
            unique case (state)
                TX_IDLE: begin
                    bus_out <= '0;
                    if (quiet && tx_valid) begin
                        bus_out <= CMD_BYTE;
                        last_q  <= 1'b0;
                        state   <= TX_CMD;
                    end
                end
                TX_CMD, TX_DATA: begin
                    if (dir) begin
                        tx_abort <= 1'b1;
                        bus_out  <= '0;
                        state    <= final_on_bus ? TX_IDLE : TX_FLUSH;
                    end else if (nxt) begin
                        if (final_on_bus) begin
                            bus_out <= '0;
                            stp     <= 1'b1;
                            state   <= TX_STOP;
                        end else begin
                            bus_out <= tx_data;
                            last_q  <= tx_last;
                            state   <= TX_DATA;
                        end
                    end
                end
                TX_STOP: begin
                    bus_out <= '0;
                    state   <= TX_IDLE;
                end
                TX_FLUSH: begin
                    bus_out <= '0;
                    if (tx_valid && tx_last) begin
                        state <= TX_IDLE;
                    end
                end
                default: begin
                    bus_out <= '0;
                    state   <= TX_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/lnk_bus_ctrl.sv
module lnk_bus_ctrl
    import lnk_bus_pkg::*;
#(
    parameter int unsigned   DW       = BUS_W,
    parameter logic [DW-1:0] CMD_BYTE = 8'h5A
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tx_valid,
    input  logic [DW-1:0] tx_data,
    input  logic          tx_last,
    output logic          tx_ready,
    output logic          tx_abort,
    input  logic          phy_dir,
    input  logic          phy_nxt,
    output logic          phy_stp,
    input  logic [DW-1:0] bus_in,
    output logic [DW-1:0] bus_out,
    output logic          bus_oe,
    output logic          rx_valid,
    output logic [DW-1:0] rx_data,
    output logic          rx_last
);

    logic dir_q;
    logic quiet;

    lnk_dir_track u_dir (
        .clk   (clk),
        .rst   (rst),
        .dir   (phy_dir),
        .dir_q (dir_q),
        .quiet (quiet),
        .oe_q  (bus_oe)
    );

    lnk_rx_path #(.DW(DW)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .dir      (phy_dir),
        .dir_q    (dir_q),
        .nxt      (phy_nxt),
        .bus_in   (bus_in),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .rx_last  (rx_last)
    );

    lnk_tx_fsm #(.DW(DW), .CMD_BYTE(CMD_BYTE)) u_tx (
        .clk      (clk),
        .rst      (rst),
        .dir      (phy_dir),
        .quiet    (quiet),
        .nxt      (phy_nxt),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .tx_last  (tx_last),
        .tx_ready (tx_ready),
        .bus_out  (bus_out),
        .stp      (phy_stp),
        .tx_abort (tx_abort)
    );

endmodule

// File: rtl/lnk_bus_chk.sv
module lnk_bus_chk #(
    parameter int unsigned DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          phy_dir,
    input logic          phy_stp,
    input logic [DW-1:0] bus_out,
    input logic          bus_oe,
    input logic          rx_valid,
    input logic          rx_last,
    input logic          tx_abort
);

    AST_RESET_STATE: assert property (@(posedge clk) $past(rst) |-> (bus_oe && bus_out == '0 && !phy_stp && !rx_valid && !tx_abort)); // R1
    AST_STP_SINGLE: assert property (@(posedge clk) disable iff (rst) phy_stp |=> !phy_stp); // R5
    AST_STP_BUS_ZERO: assert property (@(posedge clk) disable iff (rst) phy_stp |-> bus_out == '0); // R5
    AST_OE_DROP: assert property (@(posedge clk) disable iff (rst) phy_dir |=> !bus_oe); // R6
    AST_OE_TURN: assert property (@(posedge clk) disable iff (rst) (!phy_dir && $past(phy_dir)) |=> !bus_oe); // R6
    AST_RX_NEEDS_DIR: assert property (@(posedge clk) disable iff (rst) rx_valid |-> ($past(phy_dir) && $past(phy_dir, 2))); // R7
    AST_RXLAST_FALL: assert property (@(posedge clk) disable iff (rst) rx_last |-> (!$past(phy_dir) && $past(phy_dir, 2))); // R8
    AST_ABORT_NO_STP: assert property (@(posedge clk) disable iff (rst) tx_abort |-> !phy_stp); // R9

endmodule

bind lnk_bus_ctrl lnk_bus_chk #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .phy_dir  (phy_dir),
    .phy_stp  (phy_stp),
    .bus_out  (bus_out),
    .bus_oe   (bus_oe),
    .rx_valid (rx_valid),
    .rx_last  (rx_last),
    .tx_abort (tx_abort)
);

// File: tb/sim_lnk_bus_ctrl.sv
module sim_lnk_bus_ctrl;

    localparam int   CLK_PERIOD = 10;
    localparam logic [7:0] CMD = 8'h5A;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tx_valid = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_last = 1'b0;
    logic       tx_ready;
    logic       tx_abort;
    logic       phy_dir = 1'b0;
    logic       phy_nxt = 1'b0;
    logic       phy_stp;
    logic [7:0] bus_in = 8'h00;
    logic [7:0] bus_out;
    logic       bus_oe;
    logic       rx_valid;
    logic [7:0] rx_data;
    logic       rx_last;

    always #(CLK_PERIOD / 2) clk = ~clk;

    lnk_bus_ctrl #(.DW(8), .CMD_BYTE(CMD)) u0 (
        .clk(clk), .rst(rst),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
        .tx_ready(tx_ready), .tx_abort(tx_abort),
        .phy_dir(phy_dir), .phy_nxt(phy_nxt), .phy_stp(phy_stp),
        .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // bench model state
    logic [7:0] pkt [0:15];
    int  plen = 0;
    int  idx = 0;
    bit  fire = 0;
    bit  pd = 0, ppd = 0, pn = 0;
    logic [7:0] pbus = 8'h00;
    bit  exp_abort = 0;
    bit  in_pkt = 0;
    int  acc = 0;
    int  done_cnt = 0;
    int  aborts_seen = 0;
    bit  last_ready = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit exp_oe_f(input bit d1, input bit d2);
        return !d1 && !d2;
    endfunction

    function automatic logic [7:0] exp_byte_f(input int k);
        return (k == 0) ? CMD : pkt[k-1];
    endfunction

    task automatic cyc(input bit d, input bit n, input logic [7:0] din);
        bit exp_r;
        @(negedge clk);
        if (fire) begin idx++; fire = 0; end
        // check phase: outputs reflect the edge that sampled pd/pn/pbus
        chk(bus_oe == exp_oe_f(pd, ppd), "R6 oe", int'(bus_oe), int'(exp_oe_f(pd, ppd)));
        chk(rx_valid == (pd && ppd && pn), "R7 rx_valid", int'(rx_valid), int'(pd && ppd && pn));
        if (rx_valid && pd && ppd && pn)
            chk(rx_data == pbus, "R7 rx_data", int'(rx_data), int'(pbus));
        chk(rx_last == (ppd && !pd), "R8 rx_last", int'(rx_last), int'(ppd && !pd));
        chk(tx_abort == exp_abort, "R9 R10 tx_abort", int'(tx_abort), int'(exp_abort));
        if (tx_abort) aborts_seen++;
        exp_abort = 0;
        if (in_pkt && acc == plen + 1) begin
            chk(phy_stp == 1'b1, "R5 stp", int'(phy_stp), 1);
            chk(bus_out == 8'h00, "R5 bus during stp", int'(bus_out), 0);
            in_pkt = 0;
            done_cnt++;
        end else begin
            chk(phy_stp == 1'b0, "R5 stray stp", int'(phy_stp), 0);
        end
        if (!in_pkt && bus_oe && !phy_stp) begin
            if (bus_out == CMD) begin
                in_pkt = 1;
                acc = 0;
            end else begin
                chk(bus_out == 8'h00, "R2 R3 idle bus", int'(bus_out), 0);
            end
        end
        // drive phase
        phy_dir = d;
        phy_nxt = n;
        bus_in  = din;
        tx_valid = (idx < plen);
        tx_data  = (idx < plen) ? pkt[idx] : 8'h00;
        tx_last  = (idx == plen - 1);
        #1;
        last_ready = tx_ready;
        fire = tx_valid && tx_ready;
        if (in_pkt && d) begin
            exp_abort = 1;
            in_pkt = 0;
        end else if (in_pkt) begin
            exp_r = n && (acc < plen);
            chk(tx_ready == exp_r, "R4 tx_ready", int'(tx_ready), int'(exp_r));
            if (n) begin
                chk(bus_out == exp_byte_f(acc), "R3 R4 byte", int'(bus_out), int'(exp_byte_f(acc)));
                acc++;
            end
        end
        ppd = pd;
        pd  = d;
        pn  = n;
        pbus = din;
    endtask

    task automatic load_pkt(input int len);
        if (fire) begin idx++; fire = 0; end
        plen = len;
        idx = 0;
        for (int i = 0; i < len; i++) pkt[i] = 8'($urandom);
    endtask

    task automatic run_pkt(input int len, input int pct);
        int d0;
        int guard;
        d0 = done_cnt;
        guard = 0;
        load_pkt(len);
        while (done_cnt == d0 && guard < 400) begin
            cyc(0, ($urandom % 100) < pct, 8'($urandom));
            guard++;
        end
        chk(done_cnt == d0 + 1, "R5 packet finished", done_cnt - d0, 1);
        cyc(0, 0, 8'h00);
        chk(idx == plen, "R4 stream consumed", idx, plen);
    endtask

    task automatic rx_burst(input int k);
        for (int i = 0; i < k; i++) cyc(1, $urandom % 2, 8'($urandom));
        cyc(0, 0, 8'h00);
        cyc(0, 0, 8'h00);
    endtask

    task automatic abort_case(input int len, input int at);
        int a0;
        int guard;
        guard = 0;
        load_pkt(len);
        while (!(in_pkt && acc >= at) && guard < 100) begin
            cyc(0, in_pkt, 8'h00);
            guard++;
        end
        a0 = aborts_seen;
        for (int i = 0; i < 3; i++) cyc(1, 0, 8'($urandom));
        for (int i = 0; i < 12; i++) cyc(0, 0, 8'h00);
        chk(aborts_seen == a0 + 1, "R9 abort pulse", aborts_seen - a0, 1);
        chk(idx == plen, "R9 packet drained", idx, plen);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1;
        phy_dir = 0; phy_nxt = 0; tx_valid = 0; tx_last = 0;
        @(negedge clk);
        chk(bus_oe == 1'b1, "R1 oe", int'(bus_oe), 1);
        chk(bus_out == 8'h00, "R1 bus", int'(bus_out), 0);
        chk(phy_stp == 1'b0, "R1 stp", int'(phy_stp), 0);
        chk(rx_valid == 1'b0 && rx_last == 1'b0, "R1 rx", int'({rx_valid, rx_last}), 0);
        chk(tx_abort == 1'b0 && tx_ready == 1'b0, "R1 tx", int'({tx_abort, tx_ready}), 0);
        rst = 0;
        pd = 0; ppd = 0; pn = 0; in_pkt = 0; exp_abort = 0;
        fire = 0; plen = 0; idx = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R4 watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int r;
        int a0;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        do_reset();

        // R2: idle bus stays zero with strobe noise
        for (int i = 0; i < 10; i++) cyc(0, $urandom % 2, 8'($urandom));

        // directed transmits: single byte, full-rate, back-to-back
        run_pkt(1, 100);
        run_pkt(5, 100);
        run_pkt(3, 40);
        run_pkt(2, 100);

        // R7 R8: receive bursts of different lengths
        rx_burst(1);
        rx_burst(6);

        // R9: abort during command, mid-payload, with final byte waiting
        abort_case(4, 0);
        abort_case(7, 3);
        abort_case(2, 2);

        // R10: packet offered while PHY owns the bus
        load_pkt(3);
        a0 = aborts_seen;
        for (int i = 0; i < 5; i++) begin
            cyc(1, $urandom % 2, 8'($urandom));
            chk(last_ready == 1'b0, "R10 no take while dir high", int'(last_ready), 0);
        end
        begin
            int d0;
            int guard;
            d0 = done_cnt;
            guard = 0;
            while (done_cnt == d0 && guard < 100) begin
                cyc(0, 1, 8'h00);
                guard++;
            end
            chk(done_cnt == d0 + 1 && aborts_seen == a0, "R10 start after turnaround",
                done_cnt - d0, 1);
        end

        // random mix
        for (int k = 0; k < 30; k++) begin
            r = $urandom % 4;
            if (r < 2) run_pkt(1 + ($urandom % 12), 30 + ($urandom % 71));
            else if (r == 2) rx_burst(1 + ($urandom % 8));
            else for (int i = 0; i < 1 + ($urandom % 5); i++) cyc(0, $urandom % 2, 8'h00);
        end

        // R1: reset in the middle of a packet
        load_pkt(8);
        for (int i = 0; i < 4; i++) cyc(0, 1, 8'h00);
        do_reset();
        for (int i = 0; i < 4; i++) cyc(0, 1, 8'h00);
        run_pkt(4, 70);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule